// File: doc/BRIEF.md
# Bitsliced ALU with Set-Less-Than

This block is an arithmetic/logic unit built as a column of identical one-bit slices. Each slice has an AND gate, an OR gate, a full adder and a four-way result selector. The slices are chained through a ripple carry. The unit computes bitwise AND, bitwise OR, addition, subtraction and a signed set-less-than. All of these come from two operand words and a three-bit control word.

Subtraction reuses the adder. The control word's invert bit complements the B operand in every slice and also supplies the carry into the lowest slice, which forms A + ~B + 1. For set-less-than, the sum bit of the top slice is fed back to the `less` input of the lowest slice, and every other `less` input is held at 0. The block is purely combinational, so a result follows its inputs within the same cycle.

Control word layout: `ctrl[2]` is the invert bit. `ctrl[1:0]` selects the slice output: 00 is AND, 01 is OR, 10 is the adder sum, and 11 is the `less` input.

Top module: `bitslice_alu`

## Requirements
- R1: With ctrl = 000 the result is A & B.
- R2: With ctrl = 001 the result is A | B.
- R3: With ctrl = 010 the result is (A + B) mod 2^WIDTH, and any carry out of the top bit is dropped.
- R4: With ctrl = 110 the result is (A - B) mod 2^WIDTH.
- R5: With ctrl = 111, bit 0 of the result equals the top bit of (A - B) mod 2^WIDTH and all higher bits are 0. Overflow is not corrected, so A = 0x7F with B = 0x80 gives 1.
- R6: When ctrl[2] is 1, the logic paths use the complement of B: ctrl = 100 gives A & ~B and ctrl = 101 gives A | ~B.
- R7: With ctrl = 011, bit 0 of the result equals the top bit of (A + B) mod 2^WIDTH and all higher bits are 0.
- R8: The result is a pure function of the present inputs, with no clock and no stored state, and it is valid without any cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| ctrl | input | 3 | {invert B and carry-in, 2-bit output select} |
| result | output | WIDTH | Selected slice outputs |

## Verification
Every result is due in the same cycle as its stimulus, because the path has no registers. The bench therefore applies each operand and control combination and samples the result a few nanoseconds later, after the ripple chain and the top-to-bottom `less` feedback have settled and before the next stimulus is applied. The sweep covers all operand pairs under all eight control codes. The expected values are computed arithmetically in the bench.

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       ctrl,
  output logic [WIDTH-1:0] result
);
  logic       inv;
  logic [1:0] sel;

  assign inv = ctrl[2];
  assign sel = ctrl[1:0];

  for (genvar i = 0; i < WIDTH; i++) begin : slice
    logic bx, ci, co, s, lt;

    assign bx = b[i] ^ inv;

    if (i == 0) begin : g_lsb
      assign ci = inv;
      assign lt = slice[WIDTH-1].s;
    end else begin : g_up
      assign ci = slice[i-1].co;
      assign lt = 1'b0;
    end

    assign s  = a[i] ^ bx ^ ci;
    assign co = (a[i] & bx) | (ci & (a[i] ^ bx));

    always_comb begin
      case (sel)
        2'b00:   result[i] = a[i] & bx;
        2'b01:   result[i] = a[i] | bx;
        2'b10:   result[i] = s;
        default: result[i] = lt;
      endcase
    end
  end
endmodule

// File: rtl/bitslice_alu_props.sv
module bitslice_alu_props #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [2:0]       ctrl,
  input logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] diff, total;
  assign diff  = a - b;
  assign total = a + b;

  always_comb begin
    if (!$isunknown({a, b, ctrl, result})) begin
      // R1
      and_op_chk: assert (ctrl != 3'b000 || result == (a & b));
      // R2
      or_op_chk: assert (ctrl != 3'b001 || result == (a | b));
      // R3
      add_op_chk: assert (ctrl != 3'b010 || result == total);
      // R4
      sub_op_chk: assert (ctrl != 3'b110 || result == diff);
      // R5
      slt_op_chk: assert (ctrl != 3'b111 ||
                          result == {{(WIDTH-1){1'b0}}, diff[WIDTH-1]});
      // R7
      sum_sign_chk: assert (ctrl != 3'b011 ||
                            result == {{(WIDTH-1){1'b0}}, total[WIDTH-1]});
    end
  end
endmodule

bind bitslice_alu bitslice_alu_props #(.WIDTH(WIDTH)) u_props (
  .a(a), .b(b), .ctrl(ctrl), .result(result)
);

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, result;
  logic [2:0]   ctrl;
  int           tests = 0;
  int           fails = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  bitslice_alu #(.WIDTH(W)) uut (.a(a), .b(b), .ctrl(ctrl), .result(result));

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] c);
    logic [W-1:0] s, d;
    s = x + y;
    d = x - y;
    case (c)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return s;
      3'b011: return {{(W-1){1'b0}}, s[W-1]};
      3'b100: return x & ~y;
      3'b101: return x | ~y;
      3'b110: return d;
      default: return {{(W-1){1'b0}}, d[W-1]};
    endcase
  endfunction

  function automatic string tag(logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      3'b011: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [2:0] c, input string req);
    logic [W-1:0] exp;
    a = x; b = y; ctrl = c;
    #2;
    exp = model(x, y, c);
    tests++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h ctrl=%b actual=%h expected=%h",
               req, x, y, c, result, exp);
    end
  endtask

  initial begin
    a = '0; b = '0; ctrl = 3'b000;
    #3;
    tests++;
    if (result !== 8'h00) begin
      fails++;
      $display("FAIL R8 initial actual=%h expected=00", result);
    end
    apply(8'h7F, 8'h80, 3'b111, "R5");
    apply(8'h80, 8'h7F, 3'b111, "R5");
    apply(8'h55, 8'h55, 3'b111, "R5");
    apply(8'hFF, 8'h01, 3'b111, "R5");
    apply(8'hFF, 8'h01, 3'b010, "R3");
    apply(8'h00, 8'h01, 3'b110, "R4");
    apply(8'hF0, 8'h3C, 3'b100, "R6");
    apply(8'hF0, 8'h3C, 3'b101, "R6");
    apply(8'h40, 8'h40, 3'b011, "R7");
    apply(8'hAA, 8'h0F, 3'b000, "R1");
    apply(8'hAA, 8'h0F, 3'b001, "R2");
    for (int c = 0; c < 8; c++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          apply(W'(x), W'(y), 3'(c), tag(3'(c)));
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R8 watchdog expired");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule